// File: doc/BRIEF.md
# AC-link Output Frame Serializer

This block produces the outbound half of an AC'97-style codec link. It runs entirely on the bit clock that the codec supplies. Every 256 bit clocks it raises a frame sync pulse and shifts out one frame on a single serial data line. Each frame opens with a 16-bit tag slot, followed by twelve 20-bit data slots.

The tag slot is assembled from the per-slot valid flags and a two-bit codec identifier. Each data slot carries its parallel input word, most significant bit first. A slot whose flag is clear goes out as zeros. A slot marked narrow sends only its upper 16 bits and pads the rest with zeros.

All inputs are captured on the clock edge that opens a frame. Upstream logic may therefore update them freely while a frame is in flight. A per-slot one-cycle "taken" pulse tells the producer that a valid word has gone onto the wire. Once slot 12 has been carried as valid, it stays valid in every later frame until reset. Lower sample rates are carried by leaving slots unflagged in some frames.

Top module: `aclink_tx_framer`

## Requirements
- R1: While `rst` is high, `sync`, `sdout` and `slot_taken` are all low. On the first rising clock edge with `rst` low, `sync` goes high and frame 1 begins.
- R2: `sync` is high for exactly 16 consecutive clocks, and it rises once every 256 clocks.
- R3: Frame bit 0 is tag bit 15. It appears on `sdout` one clock after `sync` rises, and one new bit follows on every clock. The last bit of a frame is on `sdout` during the clock in which the next `sync` rise occurs.
- R4: The tag slot is laid out as follows. Bit 15 is the frame-valid flag. Bit 14-(k-1) flags slot k, for k = 1..12. Bit 2 is zero. Bits 1:0 carry `codec_id`.
- R5: The frame-valid flag is 1 exactly when at least one of the 12 slots is flagged valid in that frame, counting the held slot 12. Otherwise it is 0.
- R6: A slot whose flag is 0 is sent as 20 zero bits, whatever its input word holds.
- R7: Slot k takes its word from `slot_data[20k-1:20(k-1)]` and sends it most significant bit first. When `slot_narrow[k-1]` is 1, only word bits 19:4 are sent, followed by four zeros. When it is 0, all 20 bits are sent.
- R8: `slot_data`, `slot_valid`, `slot_narrow` and `codec_id` are sampled only on the clock edge at which `sync` rises. Changes made after that edge do not affect the frame in flight. They affect the next frame.
- R9: Once `slot_valid[11]` has been sampled high, slot 12 is flagged valid in every later frame, and so is the frame-valid flag. This holds until reset.
- R10: For each valid slot k, `slot_taken[k-1]` is high for exactly one clock. That clock is the one in which the slot's first bit is on `sdout`. No taken bit is raised for an invalid slot, and at most one taken bit is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Codec bit clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| codec_id | input | 2 | Identifier placed in the two lowest tag bits |
| slot_data | input | 240 | Twelve 20-bit slot words, slot 1 in the lowest bits |
| slot_valid | input | 12 | Per-slot valid flag, bit k-1 for slot k |
| slot_narrow | input | 12 | Per-slot 16-bit payload select, bit k-1 for slot k |
| sync | output | 1 | Frame sync pulse, high during the tag slot |
| sdout | output | 1 | Serial frame data, most significant bit first |
| slot_taken | output | 12 | One-clock pulse when a valid slot starts on the line |

## Verification
The embedded properties assume that `rst` is driven synchronously and that all inputs hold steady around each rising edge. They rely on nothing else, since every input is captured at a single frame-opening edge. The stimulus changes its inputs only on falling edges. In each frame it first applies deliberately wrong values just after the opening edge, then writes the intended values well before the next one. This keeps every capture clean while exercising R8. Reset is asserted only at the start, so the held slot-12 state builds up across the frame sequence exactly as the bench's model expects.

// File: rtl/aclink_tx_pkg.sv
package aclink_tx_pkg;
  localparam int unsigned TAG_BITS = 16;

  function automatic int unsigned frame_len(input int unsigned nslot, input int unsigned slotw);
    return TAG_BITS + nslot * slotw;
  endfunction
endpackage

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer #(
  parameter int unsigned NSLOT = 12,
  parameter int unsigned SLOTW = 20,
  parameter int unsigned SNW   = 4,
  parameter int unsigned PW    = 5
) (
  input  logic           clk,
  input  logic           rst,
  output logic [SNW-1:0] slot_no,
  output logic [PW-1:0]  bit_pos,
  output logic           wrap,
  output logic           sync_nxt
);
  localparam int unsigned TAGW  = aclink_tx_pkg::TAG_BITS;
  localparam int unsigned FRAME = aclink_tx_pkg::frame_len(NSLOT, SLOTW);
  localparam int unsigned CW    = $clog2(FRAME);
  localparam logic [CW-1:0] LAST     = CW'(FRAME - 1);
  localparam logic [PW-1:0] TAG_TOP  = PW'(TAGW - 1);
  localparam logic [PW-1:0] SLOT_TOP = PW'(SLOTW - 1);

  logic [CW-1:0] fc;

  always_ff @(posedge clk) begin
    if (rst) begin
      fc      <= LAST;
      slot_no <= SNW'(NSLOT);
      bit_pos <= '0;
    end else if (fc == LAST) begin
      fc      <= '0;
      slot_no <= '0;
      bit_pos <= TAG_TOP;
    end else begin
      fc <= fc + 1'b1;
      if (bit_pos == '0) begin
        slot_no <= slot_no + 1'b1;
        bit_pos <= SLOT_TOP;
      end else begin
        bit_pos <= bit_pos - 1'b1;
      end
    end
  end

  assign wrap     = (fc == LAST);
  assign sync_nxt = wrap || (fc < CW'(TAGW - 1));

  // R3: the slot walk never runs past the last data slot
  a_r3_slot_range: assert property (@(posedge clk) disable iff (rst)
    slot_no <= SNW'(NSLOT));
endmodule

// File: rtl/aclink_slot_capture.sv
module aclink_slot_capture #(
  parameter int unsigned NSLOT = 12,
  parameter int unsigned SLOTW = 20,
  parameter int unsigned IDW   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cap,
  input  logic [NSLOT*SLOTW-1:0] slot_data,
  input  logic [NSLOT-1:0]       slot_valid,
  input  logic [NSLOT-1:0]       slot_narrow,
  input  logic [IDW-1:0]         codec_id,
  output logic [NSLOT*SLOTW-1:0] data_q,
  output logic [NSLOT-1:0]       valid_q,
  output logic [NSLOT-1:0]       narrow_q,
  output logic [aclink_tx_pkg::TAG_BITS-1:0] tag
);
  localparam int unsigned TAGW = aclink_tx_pkg::TAG_BITS;

  logic [IDW-1:0] id_q;
  logic           sticky;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      valid_q  <= '0;
      narrow_q <= '0;
      id_q     <= '0;
      sticky   <= 1'b0;
    end else if (cap) begin
      data_q   <= slot_data;
      valid_q  <= slot_valid | {sticky, {(NSLOT-1){1'b0}}};
      narrow_q <= slot_narrow;
      id_q     <= codec_id;
      sticky   <= sticky | slot_valid[NSLOT-1];
    end
  end

  always_comb begin
    tag = '0;
    tag[TAGW-1] = |valid_q;
    for (int k = 0; k < NSLOT; k++) begin
      tag[TAGW-2-k] = valid_q[k];
    end
    tag[IDW-1:0] = id_q;
  end

  // R9: the held slot-12 state never drops without reset
  a_r9_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    sticky |=> sticky);
  // R9: a capture while held always flags the last slot
  a_r9_last_slot_kept: assert property (@(posedge clk) disable iff (rst)
    (sticky && cap) |=> valid_q[NSLOT-1]);
  // R8: captured values stay still between frame edges
  a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
    !cap |=> ($stable(valid_q) && $stable(data_q) && $stable(narrow_q)));
endmodule

// File: rtl/aclink_bit_select.sv
module aclink_bit_select #(
  parameter int unsigned NSLOT   = 12,
  parameter int unsigned SLOTW   = 20,
  parameter int unsigned NARROWW = 16,
  parameter int unsigned SNW     = 4,
  parameter int unsigned PW      = 5
) (
  input  logic [SNW-1:0]         slot_no,
  input  logic [PW-1:0]          bit_pos,
  input  logic [aclink_tx_pkg::TAG_BITS-1:0] tag,
  input  logic [NSLOT*SLOTW-1:0] data_q,
  input  logic [NSLOT-1:0]       valid_q,
  input  logic [NSLOT-1:0]       narrow_q,
  output logic                   bit_o
);
  localparam int unsigned TAGW = aclink_tx_pkg::TAG_BITS;
  localparam int unsigned PADW = SLOTW - NARROWW;

  always_comb begin
    bit_o = 1'b0;
    if (slot_no == '0) begin
      for (int i = 0; i < TAGW; i++) begin
        if (bit_pos == PW'(i)) bit_o = tag[i];
      end
    end else begin
      for (int k = 0; k < NSLOT; k++) begin
        if (slot_no == SNW'(k + 1) && valid_q[k]) begin
          for (int b = 0; b < SLOTW; b++) begin
            if (bit_pos == PW'(b) && !(narrow_q[k] && b < PADW)) begin
              bit_o = data_q[k*SLOTW + b];
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/aclink_tx_framer.sv
module aclink_tx_framer #(
  parameter int unsigned NSLOT   = 12,
  parameter int unsigned SLOTW   = 20,
  parameter int unsigned NARROWW = 16,
  parameter int unsigned IDW     = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [IDW-1:0]         codec_id,
  input  logic [NSLOT*SLOTW-1:0] slot_data,
  input  logic [NSLOT-1:0]       slot_valid,
  input  logic [NSLOT-1:0]       slot_narrow,
  output logic                   sync,
  output logic                   sdout,
  output logic [NSLOT-1:0]       slot_taken
);
  localparam int unsigned TAGW = aclink_tx_pkg::TAG_BITS;
  localparam int unsigned SNW  = $clog2(NSLOT + 1);
  localparam int unsigned PW   = $clog2((SLOTW > TAGW) ? SLOTW : TAGW);
  localparam int unsigned HW   = $clog2(TAGW) + 2;

  logic [SNW-1:0]         slot_no;
  logic [PW-1:0]          bit_pos;
  logic                   wrap, sync_nxt, bit_nxt;
  logic [NSLOT*SLOTW-1:0] data_q;
  logic [NSLOT-1:0]       valid_q, narrow_q;
  logic [TAGW-1:0]        tag;

  aclink_frame_timer #(.NSLOT(NSLOT), .SLOTW(SLOTW), .SNW(SNW), .PW(PW)) u_timer (
    .clk(clk), .rst(rst), .slot_no(slot_no), .bit_pos(bit_pos),
    .wrap(wrap), .sync_nxt(sync_nxt)
  );

  aclink_slot_capture #(.NSLOT(NSLOT), .SLOTW(SLOTW), .IDW(IDW)) u_capture (
    .clk(clk), .rst(rst), .cap(wrap), .slot_data(slot_data),
    .slot_valid(slot_valid), .slot_narrow(slot_narrow), .codec_id(codec_id),
    .data_q(data_q), .valid_q(valid_q), .narrow_q(narrow_q), .tag(tag)
  );

  aclink_bit_select #(.NSLOT(NSLOT), .SLOTW(SLOTW), .NARROWW(NARROWW),
                      .SNW(SNW), .PW(PW)) u_select (
    .slot_no(slot_no), .bit_pos(bit_pos), .tag(tag), .data_q(data_q),
    .valid_q(valid_q), .narrow_q(narrow_q), .bit_o(bit_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sync       <= 1'b0;
      sdout      <= 1'b0;
      slot_taken <= '0;
    end else begin
      sync  <= sync_nxt;
      sdout <= bit_nxt;
      for (int k = 0; k < NSLOT; k++) begin
        slot_taken[k] <= valid_q[k] && (slot_no == SNW'(k + 1)) &&
                         (bit_pos == PW'(SLOTW - 1));
      end
    end
  end

  // checker state: length of the current sync pulse, frame-valid bit slot
  logic [HW-1:0] hi_cnt;
  logic          fv_cycle;
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= '0;
      fv_cycle <= 1'b0;
    end else begin
      hi_cnt   <= sync ? hi_cnt + 1'b1 : '0;
      fv_cycle <= (slot_no == '0) && (bit_pos == PW'(TAGW - 1));
    end
  end

  // R1: outputs are quiet during reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!sync && !sdout && slot_taken == '0));
  // R2: each sync pulse spans the tag slot exactly
  a_r2_sync_len: assert property (@(posedge clk) disable iff (rst)
    $fell(sync) |-> hi_cnt == HW'(TAGW));
  // R5: the first tag bit on the line reflects the captured flags
  a_r5_frame_valid: assert property (@(posedge clk) disable iff (rst)
    fv_cycle |-> sdout == (|valid_q));
  // R10: never more than one taken pulse at once
  a_r10_taken_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_taken));
  // R10: a taken pulse never lasts two clocks on the same slot
  a_r10_taken_single: assert property (@(posedge clk) disable iff (rst)
    (slot_taken != '0) |=> ((slot_taken & $past(slot_taken)) == '0));
endmodule

// File: tb/aclink_tx_framer_test.sv
module aclink_tx_framer_test;
  localparam int NS = 12;
  localparam int SW = 20;
  localparam int TW = 16;
  localparam int FL = TW + NS * SW;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [1:0]      codec_id = '0;
  logic [NS*SW-1:0] slot_data = '0;
  logic [NS-1:0]   slot_valid = '0;
  logic [NS-1:0]   slot_narrow = '0;
  logic            sync, sdout;
  logic [NS-1:0]   slot_taken;

  int checks = 0;
  int errors = 0;
  bit sticky_m = 1'b0;
  logic [FL-1:0] exp_q[$];
  logic [NS-1:0] expm_q[$];

  always #5 clk = ~clk;

  aclink_tx_framer uut (
    .clk(clk), .rst(rst), .codec_id(codec_id), .slot_data(slot_data),
    .slot_valid(slot_valid), .slot_narrow(slot_narrow),
    .sync(sync), .sdout(sdout), .slot_taken(slot_taken)
  );

  task automatic chk(input bit ok, input string req, input logic [FL-1:0] act,
                     input logic [FL-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NS*SW-1:0] mkdata(input int seed);
    logic [NS*SW-1:0] d;
    for (int k = 0; k < NS; k++)
      d[k*SW +: SW] = SW'((seed * 7919 + k * 104729) ^ (k << 13) ^ 20'hA5C3E);
    return d;
  endfunction

  function automatic logic [FL-1:0] build(input logic [NS-1:0] v, input logic [NS-1:0] n,
                                          input logic [1:0] id, input logic [NS*SW-1:0] d);
    logic [TW-1:0] tag;
    logic [FL-1:0] f;
    logic [SW-1:0] w;
    tag = '0;
    tag[TW-1] = |v;
    for (int k = 0; k < NS; k++) tag[TW-2-k] = v[k];
    tag[1:0] = id;
    f = FL'(tag);
    for (int k = 0; k < NS; k++) begin
      w = v[k] ? d[k*SW +: SW] : '0;
      if (n[k]) w[3:0] = 4'b0;
      f = (f << SW) | FL'(w);
    end
    return f;
  endfunction

  // driver: apply one frame's inputs and push its expected picture
  task automatic drive(input logic [NS-1:0] v, input logic [NS-1:0] n,
                       input logic [1:0] id, input int seed);
    logic [NS-1:0] eff;
    slot_valid  = v;
    slot_narrow = n;
    codec_id    = id;
    slot_data   = mkdata(seed);
    sticky_m    = sticky_m | v[NS-1];
    eff = v | {sticky_m, {(NS-1){1'b0}}};
    exp_q.push_back(build(eff, n, id, mkdata(seed)));
    expm_q.push_back(eff);
  endtask

  task automatic wait_rise();
    logic p;
    do begin
      p = sync;
      @(negedge clk);
    end while (!(sync && !p));
  endtask

  // monitor: collect each frame and compare it against the scoreboard
  initial begin
    bit in_frame = 0;
    logic psync = 0;
    int j = 0, hi = 0, per = 0;
    bit tbad = 0;
    logic [FL-1:0] got = '0, e;
    logic [NS-1:0] tmask = '0, m;
    forever begin
      @(negedge clk);
      if (rst) begin
        in_frame = 0;
        psync = 0;
      end else begin
        if (sync && !psync) begin
          if (in_frame) begin
            got = {got[FL-2:0], sdout};
            per++;
            if (slot_taken != '0) tbad = 1;
            if (exp_q.size() > 0) begin
              e = exp_q.pop_front();
              m = expm_q.pop_front();
              chk(got == e, "R3 R4 R5 R6 R7 R8 R9 frame bits", got, e);
              chk(tmask == m && !tbad, "R10 taken pulses", FL'(tmask), FL'(m));
              chk(hi == TW && per == FL, "R2 sync width/period",
                  FL'(hi * 1000 + per), FL'(TW * 1000 + FL));
            end
          end
          in_frame = 1; j = 0; got = '0; tmask = '0; tbad = 0; hi = 1; per = 0;
        end else if (in_frame) begin
          got = {got[FL-2:0], sdout};
          per++;
          if (sync) hi++;
          if (slot_taken != '0) begin
            if (j >= TW && (j - TW) % SW == 0 && slot_taken == NS'(1 << ((j - TW) / SW)))
              tmask |= slot_taken;
            else
              tbad = 1;
          end
          j++;
        end
        psync = sync;
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    drive('0, '0, 2'd0, 1);                    // frame 1: nothing valid, frame-valid 0 (R5)
    repeat (4) @(negedge clk);
    chk(sync == 1'b0, "R1 sync in reset", FL'(sync), '0);
    chk(sdout == 1'b0, "R1 sdout in reset", FL'(sdout), '0);
    chk(slot_taken == '0, "R1 taken in reset", FL'(slot_taken), '0);
    rst = 1'b0;
    @(negedge clk);
    chk(sync == 1'b1, "R1 first sync after reset", FL'(sync), FL'(1));
    for (int f = 2; f <= 7; f++) begin
      if (f > 2) wait_rise();
      // junk right after capture must not reach the running frame (R8)
      slot_valid = ~slot_valid; slot_narrow = ~slot_narrow;
      codec_id = ~codec_id; slot_data = ~slot_data;
      repeat (60) @(negedge clk);
      case (f)
        2: drive(12'h0A5, 12'h000, 2'd1, 2);   // sparse wide slots (R4 R6)
        3: drive(12'h7FF, 12'h000, 2'd2, 3);   // all but slot 12, full width (R7)
        4: drive(12'h3F3, 12'h0F0, 2'd3, 4);   // narrow mix (R7)
        5: drive(12'h800, 12'h800, 2'd0, 5);   // slot 12 only, narrow (R9)
        6: drive(12'h000, 12'h000, 2'd2, 6);   // none requested: slot 12 held (R9 R5)
        default: drive(12'h00F, 12'h003, 2'd1, 7);
      endcase
    end
    wait_rise();
    wait_rise();
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all frames observed", FL'(exp_q.size()), '0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule